// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer with APB Register Access

This block holds eight independent 32-bit down-counters behind a single APB slave window. Software sets up a channel by writing its reload value while the channel is stopped, and then writing its control word. The control word starts the channel, picks periodic or free-running reload, and can mask the channel's interrupt line. Each time a running counter passes through zero it reloads and latches a pending flag. The pending flag can be read whether or not the channel is masked.

A pending flag is cleared by reading an end-of-interrupt location. There is one such location per channel, and one shared location that clears every channel at once. Each channel drives its own interrupt output, which is the pending flag gated by the mask. Block-level locations return every channel's masked flag, every channel's raw flag, and a fixed version word.

Top module: `tmr_multi_apb`

## Requirements
- R1: Channel n decodes at byte offsets n*0x14 + {0x00 reload, 0x04 live count, 0x08 control, 0x0C clear, 0x10 masked flag}. Block-level locations are 0xA0 (masked flags), 0xA4 (clear all), 0xA8 (raw flags) and 0xAC (version, default 32'h0001_0200). Any other offset reads zero, and writes to it are ignored.
- R2: Control bit 0 runs the channel, bit 1 selects periodic reload (1) or free-running (0), and bit 2 masks the interrupt (1 = masked). The control location reads back these three bits, with zeros above. When a control write takes bit 0 from 0 to 1, the reload value is copied into the counter at that write's clock edge.
- R3: A running counter decrements once per clock, and the live-count location returns its present value. A stopped counter holds its value and never sets its flag. Writes to the live-count location are ignored.
- R4: In periodic mode, a running counter at zero reloads from its reload register on the next edge.
- R5: In free-running mode, a running counter at zero reloads 0xFFFF_FFFF on the next edge.
- R6: Passing through zero sets the channel's raw flag whether or not the channel is masked. Bit n of 0xA8 is channel n's raw flag.
- R7: irq_o[n], bit n of 0xA0, and bit 0 of channel n's masked-flag location all equal the raw flag ANDed with the inverse of mask bit 2.
- R8: A read of channel n's clear location returns 0 and clears that channel's flag. If a zero crossing happens in the same cycle, the new setting wins.
- R9: A read of 0xA4 returns 0 and clears the flags of all channels.
- R10: Every transfer completes in its access phase: pready is 1 and pslverr is 0.
- R11: After reset, all registers, counters and flags are zero, and no interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (8) | Byte address |
| pwdata | input | DW (32) | Write data |
| prdata | output | DW (32) | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_o | output | N_TMR (8) | Per-channel interrupt, level |

## Verification
A write takes effect at the clock edge that ends its access phase. Read data comes from register state without delay, so a read returns the state left by the edge just before its access edge. The testbench puts transfers exactly three clocks apart. The expected count for a read is therefore the reload value minus the number of edges since the enabling edge. For a read placed six clocks after enabling a free-running channel loaded with 2, that gives 0xFFFF_FFFD. Interrupt outputs are combinational from the flags, so they are sampled half a clock after the edge of the transfer that changed them. All read data is sampled midway between clock edges, in the access cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control word fields, bit 0 = run, bit 1 = periodic, bit 2 = mask
  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } tmr_ctrl_t;

  localparam int CTRL_W   = 3;

  // per-channel sub-offsets
  localparam int OFF_LOAD = 'h00;
  localparam int OFF_CUR  = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_EOI  = 'h0C;
  localparam int OFF_IST  = 'h10;

  // block-level offsets
  localparam int GLB_IST  = 'hA0;
  localparam int GLB_EOI  = 'hA4;
  localparam int GLB_RAW  = 'hA8;
  localparam int GLB_VER  = 'hAC;
endpackage

// File: rtl/tmr_apb_dec.sv
module tmr_apb_dec #(
  parameter int N    = 8,
  parameter int AW   = 8,
  parameter int SLOT = 20
) (
  input  logic [AW-1:0] paddr,
  output logic [N-1:0]  chan_hit,
  output logic [AW-1:0] sub_off
);
  always_comb begin
    chan_hit = '0;
    sub_off  = '0;
    for (int n = 0; n < N; n++) begin
      if (paddr >= AW'(n * SLOT) && paddr < AW'((n + 1) * SLOT)) begin
        chan_hit[n] = 1'b1;
        sub_off     = paddr - AW'(n * SLOT);
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          eoi_clr,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] cnt_q,
  output tmr_ctrl_t     ctrl_q,
  output logic          raw_q
);
  logic start;
  logic zero_hit;

  assign start    = wr_ctrl && wdata[0] && !ctrl_q.en;
  assign zero_hit = ctrl_q.en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);

      if (start)
        cnt_q <= load_q;
      else if (zero_hit)
        cnt_q <= ctrl_q.periodic ? load_q : '1;
      else if (ctrl_q.en)
        cnt_q <= cnt_q - 1'b1;

      if (zero_hit)     raw_q <= 1'b1;
      else if (eoi_clr) raw_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_multi_apb.sv
module tmr_multi_apb
  import tmr_pkg::*;
#(
  parameter int          N_TMR   = 8,
  parameter int          DW      = 32,
  parameter int          AW      = 8,
  parameter int          SLOT    = 20,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  output logic             pslverr,
  output logic [N_TMR-1:0] irq_o
);
  logic access, wr_acc, rd_acc, geoi_rd;
  logic [N_TMR-1:0] hit;
  logic [AW-1:0]    sub;
  logic [N_TMR-1:0] en_v, per_v, msk_v, raw_v, ist_v;
  logic [N_TMR-1:0][DW-1:0] cnt_a, load_a;
  tmr_ctrl_t ctrl_a [N_TMR];

  assign access  = psel && penable;
  assign wr_acc  = access && pwrite;
  assign rd_acc  = access && !pwrite;
  assign geoi_rd = rd_acc && (paddr == AW'(GLB_EOI));
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  tmr_apb_dec #(.N(N_TMR), .AW(AW), .SLOT(SLOT)) u_dec (
    .paddr(paddr), .chan_hit(hit), .sub_off(sub)
  );

  for (genvar n = 0; n < N_TMR; n++) begin : g_ch
    tmr_chan #(.DW(DW)) u_ch (
      .clk    (pclk),
      .rst_n  (presetn),
      .wr_load(wr_acc && hit[n] && sub == AW'(OFF_LOAD)),
      .wr_ctrl(wr_acc && hit[n] && sub == AW'(OFF_CTRL)),
      .wdata  (pwdata),
      .eoi_clr(geoi_rd || (rd_acc && hit[n] && sub == AW'(OFF_EOI))),
      .load_q (load_a[n]),
      .cnt_q  (cnt_a[n]),
      .ctrl_q (ctrl_a[n]),
      .raw_q  (raw_v[n])
    );
    assign en_v[n]  = ctrl_a[n].en;
    assign per_v[n] = ctrl_a[n].periodic;
    assign msk_v[n] = ctrl_a[n].mask;
  end

  assign ist_v = raw_v & ~msk_v;
  assign irq_o = ist_v;

  always_comb begin
    prdata = '0;
    for (int n = 0; n < N_TMR; n++) begin
      if (hit[n]) begin
        case (sub)
          AW'(OFF_LOAD): prdata = load_a[n];
          AW'(OFF_CUR):  prdata = cnt_a[n];
          AW'(OFF_CTRL): prdata = DW'(ctrl_a[n]);
          AW'(OFF_IST):  prdata = DW'(ist_v[n]);
          default:       prdata = '0;
        endcase
      end
    end
    case (paddr)
      AW'(GLB_IST): prdata = DW'(ist_v);
      AW'(GLB_RAW): prdata = DW'(raw_v);
      AW'(GLB_VER): prdata = DW'(VERSION);
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_multi_apb_chk.sv
module tmr_multi_apb_chk #(
  parameter int N  = 8,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic                 pclk,
  input logic                 presetn,
  input logic                 psel,
  input logic                 penable,
  input logic                 pwrite,
  input logic [AW-1:0]        paddr,
  input logic [DW-1:0]        prdata,
  input logic                 pready,
  input logic                 pslverr,
  input logic [N-1:0]         irq_o,
  input logic [N-1:0]         en_v,
  input logic [N-1:0]         per_v,
  input logic [N-1:0]         msk_v,
  input logic [N-1:0]         raw_v,
  input logic [N-1:0][DW-1:0] cnt_a,
  input logic [N-1:0][DW-1:0] load_a
);
  p_zero_wait_r10: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable) |-> (pready && !pslverr));

  p_geoi_zero_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && paddr == AW'(tmr_pkg::GLB_EOI)) |-> (prdata == '0));

  for (genvar n = 0; n < N; n++) begin : g_a
    p_hold_r3: assert property (@(posedge pclk) disable iff (!presetn)
      !en_v[n] |=> (en_v[n] || $stable(cnt_a[n])));

    p_periodic_r4: assert property (@(posedge pclk) disable iff (!presetn)
      (en_v[n] && per_v[n] && cnt_a[n] == '0) |=> (cnt_a[n] == $past(load_a[n])));

    p_free_r5: assert property (@(posedge pclk) disable iff (!presetn)
      (en_v[n] && !per_v[n] && cnt_a[n] == '0) |=> (cnt_a[n] == '1 && raw_v[n]));

    p_raw_src_r6: assert property (@(posedge pclk) disable iff (!presetn)
      $rose(raw_v[n]) |-> $past(en_v[n]));

    p_irq_mask_r7: assert property (@(posedge pclk) disable iff (!presetn)
      irq_o[n] |-> (raw_v[n] && !msk_v[n]));
  end
endmodule

bind tmr_multi_apb tmr_multi_apb_chk #(.N(N_TMR), .DW(DW), .AW(AW)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .pready(pready),
  .pslverr(pslverr), .irq_o(irq_o), .en_v(en_v), .per_v(per_v),
  .msk_v(msk_v), .raw_v(raw_v), .cnt_a(cnt_a), .load_a(load_a)
);

// File: tb/tmr_multi_apb_tb_top.sv
module tmr_multi_apb_tb_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 pclk = ~pclk;

  tmr_multi_apb dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
  );

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    xfer(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    xfer(1'b0, a, '0);
  endtask

  task automatic chk_irq(input logic [7:0] e, input string tag);
    #5;
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq_o actual %h expected %h", tag, irq_o, e);
    end
  endtask

  // monitor: scores every access phase midway through the cycle
  initial begin
    forever begin
      @(posedge pclk);
      #15;
      if (psel && penable) begin
        checks++;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
          errors++;
          $display("FAIL R10 ready/err actual %b%b expected 10", pready, pslverr);
        end
        if (!pwrite) begin
          logic [31:0] e;
          string t;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard unexpected read actual %h expected none", prdata);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (prdata !== e) begin
              errors++;
              $display("FAIL %s addr %h actual %h expected %h", t, paddr, prdata, e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge pclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    // R11 reset state, R1 version / unmapped
    chk_irq(8'h00, "R11");
    rd(8'hAC, 32'h0001_0200, "R1");
    rd(8'h08, 32'h0, "R11");
    rd(8'hA8, 32'h0, "R11");
    rd(8'hB0, 32'h0, "R1");
    // R2/R3 channel 2 periodic, live count, hold, ignored write
    wr(8'h28, 32'd100);
    wr(8'h30, 32'h3);
    rd(8'h2C, 32'd98, "R3");
    rd(8'h2C, 32'd95, "R3");
    wr(8'h30, 32'h2);
    rd(8'h2C, 32'd91, "R3");
    wr(8'h2C, 32'h1234_5678);
    rd(8'h2C, 32'd91, "R3");
    rd(8'h28, 32'd100, "R1");
    rd(8'h30, 32'h2, "R2");
    // R5/R6 channel 3 free-running, masked
    wr(8'h3C, 32'd2);
    wr(8'h44, 32'h5);
    rd(8'hA8, 32'h0, "R6");
    rd(8'h40, 32'hFFFF_FFFD, "R5");
    rd(8'hA8, 32'h08, "R6");
    rd(8'hA0, 32'h0, "R7");
    rd(8'h4C, 32'h0, "R7");
    chk_irq(8'h00, "R7");
    // R7 unmask without reload
    wr(8'h44, 32'h1);
    chk_irq(8'h08, "R7");
    rd(8'hA0, 32'h08, "R7");
    rd(8'h4C, 32'h1, "R7");
    rd(8'h44, 32'h1, "R2");
    // R8 per-channel clear
    rd(8'h48, 32'h0, "R8");
    chk_irq(8'h00, "R8");
    rd(8'hA8, 32'h0, "R8");
    // R4 channel 5 periodic reload
    wr(8'h64, 32'd4);
    wr(8'h6C, 32'h3);
    rd(8'hA8, 32'h0, "R4");
    rd(8'h68, 32'd4, "R4");
    rd(8'h68, 32'd1, "R4");
    rd(8'hA8, 32'h20, "R6");
    chk_irq(8'h20, "R7");
    // R9 global clear with two pending channels
    wr(8'h6C, 32'h2);
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h5);
    rd(8'hA8, 32'h21, "R9");
    rd(8'hA4, 32'h0, "R9");
    rd(8'hA8, 32'h0, "R9");
    chk_irq(8'h00, "R9");
    // R2 restart copies reload again
    wr(8'h30, 32'h3);
    rd(8'h2C, 32'd98, "R2");
    wr(8'h30, 32'h0);
    // R1 last slot
    wr(8'h8C, 32'h55);
    rd(8'h8C, 32'h55, "R1");
    rd(8'h94, 32'h0, "R1");

    repeat (4) @(negedge pclk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard left %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule